// File: doc/BRIEF.md
# PC-Relative Literal Load Unit

This unit executes the three register-load forms of a 16-bit-opcode, 32-bit-datapath core that put a constant into one of sixteen general registers. One form carries a signed 8-bit constant inside the opcode itself and writes it at once. The other two fetch a constant from a literal pool placed after the code: a 16-bit halfword, which is sign-extended, or a full 32-bit word. Their address is computed from the program counter of the instruction plus a scaled, unsigned 8-bit offset.

The surrounding core offers one opcode at a time together with the address it was fetched from and a flag that marks an instruction in a branch delay slot. The unit decodes it and, for the pool forms, issues one read on a valid/ready request channel. It waits for the response and writes the result back through a single register-file write port. Any opcode outside the three forms is flagged as illegal and leaves no trace.

Top module: `lit_load_unit`

## Requirements
- R1: An opcode whose bits [15:12] are 4'hE is accepted, and in the same cycle rf_we is high, rf_waddr is bits [11:8] and rf_wdata is bits [7:0] sign-extended to 32 bits. No memory request follows.
- R2: An opcode with bits [15:12] equal to 4'h9 issues a request with mem_req_long low. Its address is (op_pc + 4) + 2 × bits [7:0], with the offset taken as unsigned.
- R3: An opcode with bits [15:12] equal to 4'hD issues a request with mem_req_long high. Its address is ((op_pc + 4) with bits [1:0] forced to 0) + 4 × bits [7:0], so it is always a multiple of 4.
- R4: With op_slot high, the base in R2 and R3 is op_pc + 2 instead of op_pc + 4. For the 4'hD form the low two bits of that base are still forced to 0.
- R5: The halfword form writes mem_rsp_data[15:0] sign-extended to 32 bits. The word form writes all 32 bits of mem_rsp_data. Both write to the register named by opcode bits [11:8].
- R6: For a pool load, rf_we is high in exactly one cycle: the cycle in which mem_rsp_valid is high after the request handshake. busy falls on the next clock.
- R7: busy rises on the clock after a pool load is accepted and stays high until its write-back. op_ready equals not busy, and after reset busy, rf_we and mem_req_valid are low.
- R8: An offered opcode with bits [15:12] other than 4'hE, 4'h9 or 4'hD drives illegal high in its accept cycle. It causes no register write and no memory request.
- R9: The address sum wraps modulo 2^32.
- R10: While mem_req_valid is high and mem_req_ready is low, the request stays valid and its address and size hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An opcode is offered |
| op_ready | output | 1 | The unit can take an opcode this cycle |
| op_code | input | 16 | Instruction word |
| op_pc | input | 32 | Fetch address of the instruction |
| op_slot | input | 1 | Instruction sits in a branch delay slot |
| illegal | output | 1 | Offered opcode is not one of the three forms |
| busy | output | 1 | A pool load is in flight |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the read |
| mem_req_long | output | 1 | 1 = 32-bit read, 0 = 16-bit read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data; a halfword is returned in bits [15:0] |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 4 | Register index written |
| rf_wdata | output | 32 | Value written |

## Verification
A wrong base, scale or alignment mask shows up as a wrong mem_req_addr in the very cycle after the load is accepted, so the per-clock comparison catches it one clock in. A stale destination index or a lost size bit only appears at write-back, as a wrong rf_waddr or a wrongly extended rf_wdata. That happens as soon as the response arrives, which the bench delays by a variable count to separate the two. A state machine stuck in its waiting state shows as busy and op_ready out of step with the model on the next clock, and the following opcode is never taken.

// File: rtl/lit_pkg.sv
package lit_pkg;
    localparam int XLEN    = 32;
    localparam int REG_W   = 4;
    localparam int OFF_W   = 8;

    localparam logic [3:0] NIB_IMM  = 4'hE;
    localparam logic [3:0] NIB_HALF = 4'h9;
    localparam logic [3:0] NIB_WORD = 4'hD;

    typedef enum logic [1:0] {
        K_IMM  = 2'd0,
        K_HALF = 2'd1,
        K_WORD = 2'd2,
        K_BAD  = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e           kind;
        logic [REG_W-1:0]   rn;
        logic [OFF_W-1:0]   field;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } ctl_state_e;

    function automatic logic [XLEN-1:0] sx8(input logic [7:0] v);
        return {{(XLEN-8){v[7]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sx16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction
endpackage

// File: rtl/lit_decode.sv
module lit_decode
    import lit_pkg::*;
(
    input  logic [15:0] code,
    output dec_t        dec
);
    always_comb begin
        dec.rn    = code[11:8];
        dec.field = code[7:0];
        unique case (code[15:12])
            NIB_IMM:  dec.kind = K_IMM;
            NIB_HALF: dec.kind = K_HALF;
            NIB_WORD: dec.kind = K_WORD;
            default:  dec.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/lit_addr_gen.sv
module lit_addr_gen
    import lit_pkg::*;
#(
    parameter int AW         = XLEN,
    parameter int PC_AHEAD   = 4,
    parameter int SLOT_AHEAD = 2
) (
    input  logic [AW-1:0]    pc,
    input  logic             slot,
    input  logic             is_word,
    input  logic [OFF_W-1:0] disp,
    output logic [AW-1:0]    addr
);
    localparam logic [AW-1:0] AHEAD_N = AW'(PC_AHEAD);
    localparam logic [AW-1:0] AHEAD_S = AW'(SLOT_AHEAD);

    logic [AW-1:0] base;
    logic [AW-1:0] base_al;
    logic [AW-1:0] off;

    always_comb begin
        base    = pc + (slot ? AHEAD_S : AHEAD_N);
        base_al = is_word ? {base[AW-1:2], 2'b00} : base;
        off     = is_word ? {{(AW-OFF_W-2){1'b0}}, disp, 2'b00}
                          : {{(AW-OFF_W-1){1'b0}}, disp, 1'b0};
        addr    = base_al + off;
    end
endmodule

// File: rtl/lit_ctrl.sv
module lit_ctrl
    import lit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  dec_t             dec,
    input  logic [XLEN-1:0]  addr_in,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic [XLEN-1:0]  rsp_data,
    output logic             busy,
    output logic             req_valid,
    output logic [XLEN-1:0]  req_addr,
    output logic             req_long,
    output logic             wb_we,
    output logic [REG_W-1:0] wb_idx,
    output logic [XLEN-1:0]  wb_data
);
    ctl_state_e       st_q;
    logic [REG_W-1:0] rn_q;
    logic [XLEN-1:0]  addr_q;
    logic             long_q;
    logic             load_go;

    assign load_go = take && (dec.kind == K_HALF || dec.kind == K_WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            rn_q   <= '0;
            addr_q <= '0;
            long_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (load_go) begin
                    st_q   <= ST_REQ;
                    rn_q   <= dec.rn;
                    addr_q <= addr_in;
                    long_q <= (dec.kind == K_WORD);
                end
                ST_REQ:  if (req_ready) st_q <= ST_WAIT;
                ST_WAIT: if (rsp_valid) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign req_valid = (st_q == ST_REQ);
    assign req_addr  = addr_q;
    assign req_long  = long_q;

    always_comb begin
        wb_we   = 1'b0;
        wb_idx  = rn_q;
        wb_data = long_q ? rsp_data : sx16(rsp_data[15:0]);
        if (st_q == ST_WAIT && rsp_valid) begin
            wb_we = 1'b1;
        end else if (take && dec.kind == K_IMM) begin
            wb_we   = 1'b1;
            wb_idx  = dec.rn;
            wb_data = sx8(dec.field);
        end
    end
endmodule

// File: rtl/lit_load_unit.sv
module lit_load_unit
    import lit_pkg::*;
#(
    parameter int PC_AHEAD   = 4,
    parameter int SLOT_AHEAD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [15:0]       op_code,
    input  logic [XLEN-1:0]   op_pc,
    input  logic              op_slot,
    output logic              illegal,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_req_addr,
    output logic              mem_req_long,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rsp_data,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [XLEN-1:0]   rf_wdata
);
    dec_t            dec;
    logic [XLEN-1:0] lit_addr;
    logic            take;

    lit_decode u_dec (
        .code (op_code),
        .dec  (dec)
    );

    lit_addr_gen #(
        .AW         (XLEN),
        .PC_AHEAD   (PC_AHEAD),
        .SLOT_AHEAD (SLOT_AHEAD)
    ) u_agen (
        .pc      (op_pc),
        .slot    (op_slot),
        .is_word (dec.kind == K_WORD),
        .disp    (dec.field),
        .addr    (lit_addr)
    );

    assign op_ready = !busy;
    assign take     = op_valid && op_ready;
    assign illegal  = take && (dec.kind == K_BAD);

    lit_ctrl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .dec       (dec),
        .addr_in   (lit_addr),
        .req_ready (mem_req_ready),
        .rsp_valid (mem_rsp_valid),
        .rsp_data  (mem_rsp_data),
        .busy      (busy),
        .req_valid (mem_req_valid),
        .req_addr  (mem_req_addr),
        .req_long  (mem_req_long),
        .wb_we     (rf_we),
        .wb_idx    (rf_waddr),
        .wb_data   (rf_wdata)
    );
endmodule

// File: rtl/lit_load_checker.sv
module lit_load_checker (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic        op_ready,
    input logic [15:0] op_code,
    input logic        illegal,
    input logic        busy,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        mem_req_long,
    input logic        rf_we,
    input logic [3:0]  rf_waddr
);
    assert_imm_same_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_code[15:12] == 4'hE)
        |-> (rf_we && rf_waddr == op_code[11:8] && !mem_req_valid));

    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_long) |-> (mem_req_addr[1:0] == 2'b00));

    assert_load_goes_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && (op_code[15:12] == 4'h9 || op_code[15:12] == 4'hD))
        |=> (busy && mem_req_valid));

    assert_no_take_when_busy_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !op_ready);

    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!rf_we && !mem_req_valid));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready)
        |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_long)));

    assert_wb_releases_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && rf_we) |=> !busy);
endmodule

bind lit_load_unit lit_load_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .op_valid      (op_valid),
    .op_ready      (op_ready),
    .op_code       (op_code),
    .illegal       (illegal),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_long  (mem_req_long),
    .rf_we         (rf_we),
    .rf_waddr      (rf_waddr)
);

// File: tb/sim_lit_load_unit.sv
`timescale 1ns/1ps
module sim_lit_load_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [15:0] op_code = 16'h0;
    logic [31:0] op_pc = 32'h0;
    logic        op_slot = 1'b0;
    logic        illegal;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_req_long;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = 32'h0;
    logic        rf_we;
    logic [3:0]  rf_waddr;
    logic [31:0] rf_wdata;

    always #2.5 clk = ~clk;

    lit_load_unit u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [35:0] q_wr[$];
    logic [32:0] q_rq[$];
    logic [31:0] rsp_word = 32'h0;
    bit          stall = 0;
    int          lat_cfg = 0;
    int          cyc = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit legal_load(input logic [3:0] n);
        return (n == 4'h9) || (n == 4'hD);
    endfunction

    // memory model: ready pattern, request capture, delayed response
    bit pend = 0;
    int lat  = 0;
    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (lat == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rsp_word;
                pend = 0;
            end else lat--;
        end
        mem_req_ready = stall ? cyc[1] : 1'b1;
        if (!rst && mem_req_valid && mem_req_ready) begin
            pend = 1;
            lat  = lat_cfg;
        end
    end

    // cycle model compared on every clock
    int m_st = 0;
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            logic exp_ill, exp_we;
            chk("R7 busy", {31'b0, busy}, {31'b0, (m_st != 0)});
            chk("R7 op_ready", {31'b0, op_ready}, {31'b0, (m_st == 0)});
            exp_ill = op_valid && (m_st == 0) && !legal_load(op_code[15:12]) && op_code[15:12] != 4'hE;
            chk("R8 illegal", {31'b0, illegal}, {31'b0, exp_ill});
            exp_we = (op_valid && m_st == 0 && op_code[15:12] == 4'hE) || (m_st == 2 && mem_rsp_valid);
            chk("R1 R6 rf_we", {31'b0, rf_we}, {31'b0, exp_we});
            if (rf_we && q_wr.size() > 0) begin
                chk("R1 R5 rf_waddr", {28'b0, rf_waddr}, {28'b0, q_wr[0][35:32]});
                chk("R1 R5 rf_wdata", rf_wdata, q_wr[0][31:0]);
                void'(q_wr.pop_front());
            end
            chk("R10 req_valid", {31'b0, mem_req_valid}, {31'b0, (m_st == 1)});
            if (mem_req_valid && q_rq.size() > 0) begin
                chk("R2 R3 R4 R9 req_addr", mem_req_addr, q_rq[0][31:0]);
                chk("R2 R3 req_long", {31'b0, mem_req_long}, {31'b0, q_rq[0][32]});
                if (mem_req_ready) void'(q_rq.pop_front());
            end
            case (m_st)
                0: if (op_valid && legal_load(op_code[15:12])) m_st = 1;
                1: if (mem_req_ready) m_st = 2;
                default: if (mem_rsp_valid) m_st = 0;
            endcase
        end
    end

    task automatic issue(input logic [15:0] op, input logic [31:0] pc, input logic slot,
                         input logic [31:0] mdata, input logic [31:0] eaddr);
        while (busy) @(negedge clk);
        rsp_word = mdata;
        case (op[15:12])
            4'hE: q_wr.push_back({op[11:8], {{24{op[7]}}, op[7:0]}});
            4'h9: begin
                q_wr.push_back({op[11:8], {{16{mdata[15]}}, mdata[15:0]}});
                q_rq.push_back({1'b0, eaddr});
            end
            4'hD: begin
                q_wr.push_back({op[11:8], mdata});
                q_rq.push_back({1'b1, eaddr});
            end
            default: ;
        endcase
        op_code  = op;
        op_pc    = pc;
        op_slot  = slot;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = 16'h0000;
    endtask

    function automatic logic [31:0] ref_addr(input logic [15:0] op, input logic [31:0] pc, input logic slot);
        logic [31:0] b;
        b = pc + (slot ? 32'd2 : 32'd4);
        if (op[15:12] == 4'hD) return (b & 32'hFFFF_FFFC) + 32'(op[7:0]) * 4;
        return b + 32'(op[7:0]) * 2;
    endfunction

    task automatic settle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R7 reset state
        chk("R7 reset busy", {31'b0, busy}, 32'd0);
        chk("R7 reset rf_we", {31'b0, rf_we}, 32'd0);
        chk("R7 reset req_valid", {31'b0, mem_req_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 immediates
        issue(16'hE380, 32'h100, 0, 0, 0);
        issue(16'hE57F, 32'h102, 0, 0, 0);
        issue(16'hEFFF, 32'h104, 1, 0, 0);
        // R2 R5 halfword, max offset, bit 15 set
        issue(16'h92FF, 32'h0000_1000, 0, 32'h1234_8001, 32'h0000_1202);
        issue(16'h9A10, 32'h0000_4000, 0, 32'hABCD_7FFE, 32'h0000_4024);
        // R3 word, max offset on unaligned pc
        issue(16'hD4FF, 32'h0000_1002, 0, 32'hDEAD_BEEF, 32'h0000_1400);
        issue(16'hD600, 32'h0000_1000, 0, 32'h0000_0001, 32'h0000_1004);
        // R4 delay slot base
        issue(16'h9103, 32'h0000_2000, 1, 32'h0000_FFFF, 32'h0000_2008);
        issue(16'hD701, 32'h0000_2000, 1, 32'h8000_0000, 32'h0000_2004);
        issue(16'hD801, 32'h0000_2002, 1, 32'h7654_3210, 32'h0000_2008);
        // R9 wrap
        issue(16'hD901, 32'hFFFF_FFFE, 0, 32'h0000_00AA, 32'h0000_0004);
        issue(16'h9BFF, 32'hFFFF_FFF0, 0, 32'h0000_0055, 32'h0000_01F2);
        // R8 illegal opcodes
        issue(16'h6123, 32'h300, 0, 0, 0);
        issue(16'h0000, 32'h302, 0, 0, 0);
        issue(16'hF0FF, 32'h304, 0, 0, 0);
        settle();
        // R10 R6 stalls and response latency
        stall = 1; lat_cfg = 3;
        issue(16'hDCFF, 32'h0000_5006, 0, 32'h1111_2222, 32'h0000_5404);
        issue(16'h9D80, 32'h0000_6000, 1, 32'hCAFE_9876, 32'h0000_6102);
        issue(16'hE2AA, 32'h0000_6002, 0, 0, 0);
        settle();
        // mixed traffic
        begin
            logic [31:0] s;
            s = 32'h1357_9BDF;
            for (int i = 0; i < 60; i++) begin
                logic [15:0] op;
                logic [31:0] pc;
                logic        sl;
                s = s * 32'd1664525 + 32'd1013904223;
                stall   = s[3];
                lat_cfg = int'(s[5:4]);
                case (s[9:8])
                    2'd0: op = {4'hE, s[19:12]};
                    2'd1: op = {4'h9, s[19:12]};
                    2'd2: op = {4'hD, s[19:12]};
                    default: op = {4'h3, s[19:12]};
                endcase
                pc = {s[31:21], s[16:0], 1'b0} ^ 32'h0;
                sl = s[10];
                issue(op, pc, sl, {s[15:0], s[31:16]}, ref_addr(op, pc, sl));
            end
        end
        settle();
        chk("R6 writes drained", q_wr.size(), 0);
        chk("R2 R3 requests drained", q_rq.size(), 0);
        finish_run();
    end
endmodule